// File: doc/BRIEF.md
# Mirrored Secure/Non-Secure Address Decoder

This block sits at the entry of a 32-bit system bus and decides, for every request address, which on-chip target is addressed and at which target-local offset. The address space is split into 256 MB regions. The devices of the even regions 0x0, 0x2 and 0x4 appear a second time in the odd regions 0x1, 0x3 and 0x5, which serve as the secure view of the same hardware. Before any mirror is applied, a set of explicitly placed device windows is checked against the raw address. Some of these windows sit only inside region 0x5, so those devices can only be reached through the secure view.

The decoded result is a one-hot select over SRAM banks, the register windows of the SRAM protection controllers, three timer slots, a slow timer, a system-info block, a system-control block, three watchdogs, a security-controller window and a fallback board-memory target. The select and the offset are registered. A request is taken with a valid/ready pair. The response is held until the consumer takes it.

The SRAM bank count and the bank address width are parameters. The bank count must be a power of two, and the width must lie between 1 and 24 − log2(bank count). Illegal values stop elaboration.

Top module: `secmir_decoder`

## Requirements
- R1: While reset is low and in the first cycle after reset, `rsp_valid` is 0 and `req_ready` is 1.
- R2: A request accepted at a clock edge (`req_valid` and `req_ready` both 1) produces `rsp_valid`=1 after that edge, with exactly one `rsp_sel` bit set. While `rsp_valid`=1 and `rsp_ready`=0, the response is held unchanged and `req_ready` is 0. When `rsp_ready` is 1, a new request can be accepted in the same cycle.
- R3: Select bit layout, with NB banks: bits 0..NB-1 are the SRAM banks, bits NB..2NB-1 are the protection-controller windows, and then, from bit 2NB upwards: timer0, timer1, timer2, slow timer, system info, system control, slow watchdog, non-secure watchdog, secure watchdog, security controller, board memory. SRAM bank i covers 0x2000_0000 + i·2^BANK_AW for 2^BANK_AW bytes, and its offset is address − base.
- R4: Region 0x3 mirrors region 0x2. An address 0x3xxx_xxxx decodes exactly as the same address with bit 28 cleared, and the offset is taken from the folded address.
- R5: 4 KB non-secure device windows: timer0 at 0x4000_0000, timer1 at 0x4000_1000, timer2 at 0x4000_2000, system info at 0x4002_0000, slow timer at 0x4002_F000, security controller at 0x4008_0000, non-secure watchdog at 0x4008_1000. The offset is the low 12 address bits.
- R6: Region 0x5 mirrors region 0x4 wherever no explicit window matches the raw address. An explicit window matching the raw address always wins over the mirror; for example, 0x5008_1000 selects the secure watchdog, not the non-secure one.
- R7: Secure-only 4 KB windows: system control at 0x5002_1000, slow watchdog at 0x5002_E000, secure watchdog at 0x5008_1000, security controller at 0x5008_0000, and protection-controller window i at 0x5008_3000 + i·0x1000. The same addresses with bit 28 cleared do not select the secure-only devices.
- R8: Any address that matches no window, neither raw nor after folding, selects board memory. The offset is the folded address for regions 0x1, 0x3 and 0x5, and the raw address everywhere else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Decoder can take a request |
| req_addr | input | 32 | Request address |
| rsp_valid | output | 1 | Decoded response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_sel | output | 2·NUM_BANKS+11 | One-hot target select (layout in R3) |
| rsp_offset | output | 32 | Target-local offset |

## Verification
The decode itself is combinational, and one register stage stands between a request and its result. The select and the offset for a request accepted at edge N are therefore visible after edge N and are sampled at the falling edge that follows. The bench drives inputs on falling edges and checks each response exactly one cycle after acceptance. In the back-pressure scenario, it checks that the held response stays unchanged on each stalled falling edge, and that the queued request appears one cycle after `rsp_ready` returns.

// File: rtl/secmir_pkg.sv
// Package: select layout and window table for the mirrored address decoder.
// Assumes every window base is aligned to its own power-of-two size.
package secmir_pkg;

    // Fixed targets, numbered upward from select bit 2*NUM_BANKS.
    localparam int F_TIMER0   = 0;
    localparam int F_TIMER1   = 1;
    localparam int F_TIMER2   = 2;
    localparam int F_SLOWTMR  = 3;
    localparam int F_SYSINFO  = 4;
    localparam int F_SYSCTL   = 5;
    localparam int F_SLOWWDOG = 6;
    localparam int F_NSWDOG   = 7;
    localparam int F_SWDOG    = 8;
    localparam int F_SECCTL   = 9;
    localparam int F_BOARD    = 10;
    localparam int NUM_FIXED  = 11;

    // Window entry idx -> base address. Entry 2nb+10 is the second
    // (non-secure) security-controller window; it shares a select bit
    // with the secure one.
    function automatic logic [31:0] ent_base(input int idx, input int nb, input int aw);
        logic [31:0] b;
        if (idx < nb) begin
            b = 32'h2000_0000 + (32'(idx) << aw);
        end else if (idx < 2 * nb) begin
            b = 32'h5008_3000 + (32'(idx - nb) << 12);
        end else begin
            case (idx - 2 * nb)
                F_TIMER0:   b = 32'h4000_0000;
                F_TIMER1:   b = 32'h4000_1000;
                F_TIMER2:   b = 32'h4000_2000;
                F_SLOWTMR:  b = 32'h4002_F000;
                F_SYSINFO:  b = 32'h4002_0000;
                F_SYSCTL:   b = 32'h5002_1000;
                F_SLOWWDOG: b = 32'h5002_E000;
                F_NSWDOG:   b = 32'h4008_1000;
                F_SWDOG:    b = 32'h5008_1000;
                F_SECCTL:   b = 32'h5008_0000;
                default:    b = 32'h4008_0000;
            endcase
        end
        return b;
    endfunction

    // Window entry idx -> log2 of its size in bytes.
    function automatic int ent_lg2(input int idx, input int nb, input int aw);
        return (idx < nb) ? aw : 12;
    endfunction

endpackage

// File: rtl/secmir_fold.sv
// Mirror folding: clears address bit 28 for regions 0x1, 0x3 and 0x5, so
// that those regions decode as regions 0x0, 0x2 and 0x4. No other region
// is mirrored.
module secmir_fold (
    input  logic [31:0] addr,
    output logic [31:0] folded,
    output logic        is_mirror
);

    // Decide whether the region takes part in mirroring, then fold it.
    always_comb begin
        is_mirror = (addr[31:28] == 4'h1) || (addr[31:28] == 4'h3) ||
                    (addr[31:28] == 4'h5);
        folded    = is_mirror ? {addr[31:29], 1'b0, addr[27:0]} : addr;
    end

endmodule

// File: rtl/secmir_match.sv
// Window matcher: compares one address against every explicit window and
// returns a hit flag, a select vector (board bit excluded) and the offset
// from the matching window's base. Assumes the windows do not overlap,
// which the fixed table and the legal SRAM range guarantee.
module secmir_match
    import secmir_pkg::*;
#(
    parameter  int NUM_BANKS = 4,
    parameter  int BANK_AW   = 15,
    localparam int NUM_ENT   = 2 * NUM_BANKS + NUM_FIXED,
    localparam int SEL_W     = NUM_ENT - 1
) (
    input  logic [31:0]      addr,
    output logic             hit,
    output logic [SEL_W-1:0] sel,
    output logic [31:0]      offset
);

    localparam int SECCTL_BIT = 2 * NUM_BANKS + F_SECCTL;

    logic [NUM_ENT-1:0] ent_hit;
    logic [31:0]        ent_off [NUM_ENT];

    // One aligned compare and one offset subtract per window.
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_win
        localparam logic [31:0] BASE = ent_base(g, NUM_BANKS, BANK_AW);
        localparam int          LG   = ent_lg2(g, NUM_BANKS, BANK_AW);
        assign ent_hit[g] = (addr[31:LG] == BASE[31:LG]);
        assign ent_off[g] = ent_hit[g] ? (addr - BASE) : 32'd0;
    end

    // Merge the per-window offsets; at most one is non-zero.
    always_comb begin
        offset = 32'd0;
        for (int i = 0; i < NUM_ENT; i++) begin
            offset = offset | ent_off[i];
        end
    end

    // Map window hits to select bits; both controller windows share one bit.
    always_comb begin
        sel             = ent_hit[SEL_W-1:0];
        sel[SECCTL_BIT] = ent_hit[SECCTL_BIT] | ent_hit[NUM_ENT-1];
        hit             = |ent_hit;
    end

endmodule

// File: rtl/secmir_rsp_reg.sv
// Response register: captures the decoded select and offset when a request
// is accepted, and holds them until the consumer asserts ready.
module secmir_rsp_reg #(
    parameter int SEL_W = 19
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             accept,
    input  logic [SEL_W-1:0] sel_in,
    input  logic [31:0]      off_in,
    input  logic             rsp_ready,
    output logic             rsp_valid,
    output logic [SEL_W-1:0] rsp_sel,
    output logic [31:0]      rsp_offset
);

    // Load on accept, drop valid once consumed, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            rsp_sel    <= '0;
            rsp_offset <= 32'd0;
        end else if (accept) begin
            rsp_valid  <= 1'b1;
            rsp_sel    <= sel_in;
            rsp_offset <= off_in;
        end else if (rsp_ready) begin
            rsp_valid  <= 1'b0;
        end
    end

endmodule

// File: rtl/secmir_decoder.sv
// Top: mirrored secure/non-secure address decoder. The priority order is:
// explicit window on the raw address, then explicit window on the folded
// address (mirror regions only), then board memory. The result is
// registered, with one cycle of latency. Assumes a power-of-two bank count
// and a bank width between 1 and 24 - log2(NUM_BANKS).
module secmir_decoder
    import secmir_pkg::*;
#(
    parameter  int NUM_BANKS = 4,
    parameter  int BANK_AW   = 15,
    localparam int SEL_W     = 2 * NUM_BANKS + NUM_FIXED,
    localparam int MSEL_W    = SEL_W - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [31:0]      req_addr,
    output logic             rsp_valid,
    input  logic             rsp_ready,
    output logic [SEL_W-1:0] rsp_sel,
    output logic [31:0]      rsp_offset
);

    localparam int BANK_LG2 = $clog2(NUM_BANKS);
    localparam int AW_MAX   = 24 - BANK_LG2;

    // Elaboration guard on the SRAM geometry.
    if ((NUM_BANKS < 1) || ((NUM_BANKS & (NUM_BANKS - 1)) != 0)) begin : g_bad_banks
        $error("secmir_decoder: NUM_BANKS must be a power of two");
    end
    if ((BANK_AW < 1) || (BANK_AW > AW_MAX)) begin : g_bad_aw
        $error("secmir_decoder: BANK_AW outside 1..24-log2(NUM_BANKS)");
    end

    logic [31:0]       folded;
    logic              is_mirror;
    logic              raw_hit, mir_hit;
    logic [MSEL_W-1:0] raw_sel, mir_sel;
    logic [31:0]       raw_off, mir_off;
    logic [SEL_W-1:0]  dec_sel;
    logic [31:0]       dec_off;
    logic              accept;

    secmir_fold u_fold (
        .addr      (req_addr),
        .folded    (folded),
        .is_mirror (is_mirror)
    );

    secmir_match #(.NUM_BANKS(NUM_BANKS), .BANK_AW(BANK_AW)) u_raw (
        .addr   (req_addr),
        .hit    (raw_hit),
        .sel    (raw_sel),
        .offset (raw_off)
    );

    secmir_match #(.NUM_BANKS(NUM_BANKS), .BANK_AW(BANK_AW)) u_mir (
        .addr   (folded),
        .hit    (mir_hit),
        .sel    (mir_sel),
        .offset (mir_off)
    );

    // Priority: raw window, then mirrored window, then board memory.
    always_comb begin
        if (raw_hit) begin
            dec_sel = {1'b0, raw_sel};
            dec_off = raw_off;
        end else if (is_mirror && mir_hit) begin
            dec_sel = {1'b0, mir_sel};
            dec_off = mir_off;
        end else begin
            dec_sel = {1'b1, {MSEL_W{1'b0}}};
            dec_off = folded;
        end
    end

    // Accept when the response slot is free or being drained this cycle.
    always_comb begin
        req_ready = !rsp_valid || rsp_ready;
        accept    = req_valid && req_ready;
    end

    secmir_rsp_reg #(.SEL_W(SEL_W)) u_rsp (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .sel_in     (dec_sel),
        .off_in     (dec_off),
        .rsp_ready  (rsp_ready),
        .rsp_valid  (rsp_valid),
        .rsp_sel    (rsp_sel),
        .rsp_offset (rsp_offset)
    );

endmodule

// File: rtl/secmir_decoder_chk.sv
// Checker for secmir_decoder: handshake and decode-range properties. It
// keeps its own copy of the last accepted address.
module secmir_decoder_chk
    import secmir_pkg::*;
#(
    parameter  int NUM_BANKS = 4,
    localparam int SEL_W     = 2 * NUM_BANKS + NUM_FIXED
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [31:0]      req_addr,
    input logic             rsp_valid,
    input logic             rsp_ready,
    input logic [SEL_W-1:0] rsp_sel,
    input logic [31:0]      rsp_offset
);

    localparam int FB = 2 * NUM_BANKS;

    logic [31:0] cap_addr;
    logic        sec_only_sel;
    logic        periph_sel;

    // Remember the address of the request whose response is pending.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_addr <= 32'd0;
        else if (req_valid && req_ready) cap_addr <= req_addr;
    end

    // Classify the presented select.
    always_comb begin
        sec_only_sel = (|rsp_sel[FB-1:NUM_BANKS]) || rsp_sel[FB+F_SYSCTL] ||
                       rsp_sel[FB+F_SLOWWDOG] || rsp_sel[FB+F_SWDOG];
        periph_sel   = |rsp_sel[SEL_W-2:FB];
    end

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !rsp_valid);

    a_r2_resp_next: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_sel) && $stable(rsp_offset)));

    a_r2_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones(rsp_sel) == 1));

    a_r3_sram_range: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && (|rsp_sel[NUM_BANKS-1:0])) |-> (cap_addr[31:29] == 3'b001));

    a_r5_periph_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && periph_sel) |-> (rsp_offset < 32'h1000));

    a_r7_secure_only: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && sec_only_sel) |-> (cap_addr[31:28] == 4'h5));

endmodule

bind secmir_decoder secmir_decoder_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_addr   (req_addr),
    .rsp_valid  (rsp_valid),
    .rsp_ready  (rsp_ready),
    .rsp_sel    (rsp_sel),
    .rsp_offset (rsp_offset)
);

// File: tb/secmir_decoder_tb.sv
// Directed bench for secmir_decoder with defaults NUM_BANKS=4, BANK_AW=15.
// Select bits: 0-3 banks, 4-7 controller windows, 8 timer0, 9 timer1,
// 10 timer2, 11 slow timer, 12 sysinfo, 13 sysctl, 14 slow wdog,
// 15 ns wdog, 16 s wdog, 17 security ctrl, 18 board.
module secmir_decoder_tb;

    localparam int SW = 19;
    localparam int S_TMR0 = 8, S_TMR1 = 9, S_TMR2 = 10, S_SLOWT = 11, S_INFO = 12;
    localparam int S_SCTL = 13, S_SWD32 = 14, S_NSWD = 15, S_SWD = 16, S_SEC = 17;
    localparam int S_BOARD = 18;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [31:0]   req_addr = 32'd0;
    logic          rsp_valid;
    logic          rsp_ready = 1'b1;
    logic [SW-1:0] rsp_sel;
    logic [31:0]   rsp_offset;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #5 clk = ~clk;

    secmir_decoder u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_addr   (req_addr),
        .rsp_valid  (rsp_valid),
        .rsp_ready  (rsp_ready),
        .rsp_sel    (rsp_sel),
        .rsp_offset (rsp_offset)
    );

    task automatic check_rsp(input string req, input int idx, input logic [31:0] off);
        logic [SW-1:0] exp_sel;
        exp_sel = SW'(1) << idx;
        n_checks++;
        if (!(rsp_valid === 1'b1 && rsp_sel === exp_sel && rsp_offset === off)) begin
            n_fails++;
            $display("FAIL %s: valid=%b sel=%h off=%h expected valid=1 sel=%h off=%h",
                     req, rsp_valid, rsp_sel, rsp_offset, exp_sel, off);
        end
    endtask

    // Issue one request and check its response one cycle after acceptance.
    task automatic send(input logic [31:0] a, input int idx, input logic [31:0] off,
                        input string req);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp(req, idx, off);
    endtask

    task automatic t_reset;
        @(negedge clk);
        n_checks++;
        if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
            n_fails++;
            $display("FAIL R1: in reset valid=%b ready=%b expected 0/1", rsp_valid, req_ready);
        end
        rst_n = 1'b1;
        @(negedge clk);
        n_checks++;
        if (rsp_valid !== 1'b0 || req_ready !== 1'b1) begin
            n_fails++;
            $display("FAIL R1: after reset valid=%b ready=%b expected 0/1", rsp_valid, req_ready);
        end
    endtask

    task automatic t_sram;
        send(32'h2000_0000, 0, 32'h0,    "R3 bank0 base");
        send(32'h2000_7FFC, 0, 32'h7FFC, "R3 bank0 top");
        send(32'h2000_8010, 1, 32'h10,   "R3 bank1");
        send(32'h2001_8004, 3, 32'h4,    "R3 bank3");
        send(32'h2002_0000, S_BOARD, 32'h2002_0000, "R8 past last bank");
    endtask

    task automatic t_sram_mirror;
        send(32'h3000_0100, 0, 32'h100,  "R4 mirror bank0");
        send(32'h3001_0008, 2, 32'h8,    "R4 mirror bank2");
        send(32'h3002_0000, S_BOARD, 32'h2002_0000, "R4 mirror beyond banks");
    endtask

    task automatic t_periph_ns;
        send(32'h4000_0004, S_TMR0,  32'h4,   "R5 timer0");
        send(32'h4000_1FFC, S_TMR1,  32'hFFC, "R5 timer1");
        send(32'h4000_2010, S_TMR2,  32'h10,  "R5 timer2");
        send(32'h4002_F020, S_SLOWT, 32'h20,  "R5 slow timer");
        send(32'h4002_0FD0, S_INFO,  32'hFD0, "R5 sysinfo");
        send(32'h4008_0040, S_SEC,   32'h40,  "R5 secctl ns window");
        send(32'h4008_1008, S_NSWD,  32'h8,   "R5 ns watchdog");
    endtask

    task automatic t_periph_mirror;
        send(32'h5000_0004, S_TMR0,  32'h4,   "R6 mirrored timer0");
        send(32'h5002_F000, S_SLOWT, 32'h0,   "R6 mirrored slow timer");
        send(32'h5002_0100, S_INFO,  32'h100, "R6 mirrored sysinfo");
        send(32'h5008_1000, S_SWD,   32'h0,   "R6 explicit beats mirror");
    endtask

    task automatic t_secure_only;
        send(32'h5002_1010, S_SCTL,  32'h10,  "R7 sysctl");
        send(32'h5002_E004, S_SWD32, 32'h4,   "R7 slow watchdog");
        send(32'h5008_0FFC, S_SEC,   32'hFFC, "R7 secctl s window");
        send(32'h5008_3000, 4,       32'h0,   "R7 ctrl window 0");
        send(32'h5008_6008, 7,       32'h8,   "R7 ctrl window 3");
        send(32'h4002_1000, S_BOARD, 32'h4002_1000, "R7 sysctl not in ns");
        send(32'h4002_E000, S_BOARD, 32'h4002_E000, "R7 slow wdog not in ns");
        send(32'h4008_3000, S_BOARD, 32'h4008_3000, "R7 ctrl window not in ns");
    endtask

    task automatic t_board;
        send(32'h0000_1234, S_BOARD, 32'h0000_1234, "R8 region0");
        send(32'h1234_5678, S_BOARD, 32'h0234_5678, "R8 region1 folded");
        send(32'h7000_0010, S_BOARD, 32'h7000_0010, "R8 region7 unfolded");
        send(32'hE000_0000, S_BOARD, 32'hE000_0000, "R8 high region");
        send(32'h5F00_0000, S_BOARD, 32'h4F00_0000, "R8 region5 folded");
    endtask

    task automatic t_backpressure;
        @(negedge clk);
        rsp_ready = 1'b0;
        req_valid = 1'b1;
        req_addr  = 32'h4000_1004;
        @(negedge clk);
        req_addr  = 32'h2000_8000;
        check_rsp("R2 first response", S_TMR1, 32'h4);
        n_checks++;
        if (req_ready !== 1'b0) begin
            n_fails++;
            $display("FAIL R2: req_ready=%b expected 0 while stalled", req_ready);
        end
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            check_rsp("R2 held while stalled", S_TMR1, 32'h4);
        end
        rsp_ready = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check_rsp("R2 queued request after release", 1, 32'h0);
        @(negedge clk);
        n_checks++;
        if (rsp_valid !== 1'b0) begin
            n_fails++;
            $display("FAIL R2: rsp_valid=%b expected 0 after drain", rsp_valid);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_sram();
        t_sram_mirror();
        t_periph_ns();
        t_periph_mirror();
        t_secure_only();
        t_board();
        t_backpressure();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: bench did not complete, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule